// File: doc/BRIEF.md
# Packed Nibble Tag Checker

This block decides whether a memory access may proceed by comparing the 4-bit tag carried in a pointer with the allocation tag of every 16-byte granule that the access touches. Allocation tags sit in a tag memory, two to a byte. The block reads that memory one byte per cycle through a synchronous read port. It stops at the first granule whose tag disagrees with the pointer tag.

A request gives the start address, the access length minus one, the pointer tag and an enable. The enable says whether tag checking applies to the pointer's half of the address space. When checking is off, the access passes at once and no tag memory is read. Otherwise the block works out which granules the access covers and walks them in address order. It finishes with a one-cycle done pulse, a pass flag and the address of the first failing granule.

Top module: `nib_tag_checker`

## Requirements
- R1: Granule g (address bits [AW-1:4]) has its tag in tag byte g>>1, which is also the start address shifted right by 5. When g is even the tag is in bits [3:0], and when g is odd it is in bits [7:4]. The first tag byte read for a request is start>>5.
- R2: The checked granules run from granule(start) to granule(start+size_m1), both included. That is between 1 and 17 granules for size_m1 from 0 to 255.
- R3: When start bit 4 is set, the low nibble of the first tag byte is not compared. A mismatch held there does not cause a fail.
- R4: The result is a pass when every checked granule's tag equals the pointer tag. Otherwise it is a fail, and the check stops at the lowest failing granule.
- R5: When the first checked granule fails, fault_addr_o equals the unaligned start address.
- R6: When granule n>0 of the access fails, fault_addr_o equals (start with bits [3:0] cleared) + 16*n.
- R7: With chk_en_i low, done_o and pass_o are high on the cycle after the request is accepted, and no tag read is issued.
- R8: done_o is a one-cycle pulse. pass_o and fault_addr_o hold their values until the next completion. fault_addr_o is zero on a pass.
- R9: Each cycle issues at most one tag read, at consecutive byte indices. A checked request raises done_o B+1 cycles after the request is accepted, where B is the number of tag bytes compared up to the stop point. It issues exactly B reads.
- R10: req_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a check (accepted when not busy) |
| chk_en_i | input | 1 | Tag checking enabled for this pointer |
| addr_i | input | AW | Access start address |
| size_m1_i | input | SW | Access length in bytes minus one |
| ptr_tag_i | input | 4 | Tag carried by the pointer |
| busy_o | output | 1 | Check in progress |
| mem_req_o | output | 1 | Tag memory read strobe |
| mem_addr_o | output | AW-5 | Tag byte index |
| mem_rdata_i | input | 8 | Tag byte, valid the cycle after mem_req_o |
| done_o | output | 1 | Completion pulse |
| pass_o | output | 1 | Result of last check |
| fault_addr_o | output | AW | First failing address (zero on pass) |

## Verification
The assertions assume a few things about the inputs. The tag memory must return the addressed byte exactly one cycle after the read strobe. The start address plus the length must not wrap past the top of the address space, since the fault-address range check compares against an unwrapped end. The stimulus keeps every address below 0x1000. It backs the read port with a small bench array that answers on the next edge. It also drives a second request in the middle of a check to exercise the ignore rule, and that request is never left pending when a check completes.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CMP   = 2'd2
  } tc_state_e;
endpackage

// File: rtl/tagchk_span.sv
module tagchk_span #(
  parameter int AW = 32,
  parameter int SW = 8,
  parameter int GL = 4,
  parameter int CW = 6,
  localparam int IW = AW - GL - 1,
  localparam int LW = GL + CW
) (
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_m1_i,
  output logic [AW-1:0] base_o,
  output logic [IW-1:0] idx_o,
  output logic          odd_o,
  output logic [CW-1:0] count_o
);
  assign base_o = {addr_i[AW-1:GL], {GL{1'b0}}};
  assign idx_o  = addr_i[AW-1:GL+1];
  assign odd_o  = addr_i[GL];
  // modulo 2^CW is exact: count never exceeds 2^(SW-GL)+1
  assign count_o = CW'(((LW'(addr_i[LW-1:0]) + LW'(size_m1_i)) >> GL)
                       - (LW'(addr_i[LW-1:0]) >> GL) + LW'(1));
endmodule

// File: rtl/tagchk_nib_cmp.sv
module tagchk_nib_cmp #(
  parameter int CW = 6
) (
  input  logic [7:0]    byte_i,
  input  logic [3:0]    tag_i,
  input  logic          odd_i,
  input  logic [CW-1:0] left_i,
  output logic          mis_o,
  output logic          pos_o,
  output logic [1:0]    used_o,
  output logic          fin_o
);
  logic [7:0] diff;
  logic lo_bad, hi_bad;

  assign diff   = byte_i ^ {tag_i, tag_i};
  assign lo_bad = |diff[3:0];
  assign hi_bad = |diff[7:4];

  always_comb begin
    mis_o  = 1'b0;
    pos_o  = 1'b0;
    used_o = 2'd1;
    if (odd_i) begin
      mis_o = hi_bad;
    end else if (lo_bad) begin
      mis_o = 1'b1;
    end else if (left_i > CW'(1)) begin
      used_o = 2'd2;
      mis_o  = hi_bad;
      pos_o  = 1'b1;
    end
  end

  assign fin_o = mis_o || (left_i == CW'(used_o));
endmodule

// File: rtl/nib_tag_checker.sv
module nib_tag_checker #(
  parameter int AW = 32,
  parameter int SW = 8,
  parameter int GL = 4,
  localparam int IW = AW - GL - 1,
  localparam int CW = SW - GL + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          chk_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_m1_i,
  input  logic [3:0]    ptr_tag_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [IW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] fault_addr_o
);
  import tagchk_pkg::*;

  tc_state_e     st_q;
  logic [AW-1:0] start_q, base_q, fault_q;
  logic [IW-1:0] idx_q;
  logic          odd_q, done_q, pass_q;
  logic [CW-1:0] left_q, n_q;
  logic [3:0]    tag_q;

  logic [AW-1:0] sp_base;
  logic [IW-1:0] sp_idx;
  logic          sp_odd;
  logic [CW-1:0] sp_cnt;

  logic          c_mis, c_pos, c_fin;
  logic [1:0]    c_used;
  logic [CW-1:0] f_n;
  logic [AW-1:0] f_addr;
  logic          accept;

  tagchk_span #(.AW(AW), .SW(SW), .GL(GL), .CW(CW)) u_span (
    .addr_i    (addr_i),
    .size_m1_i (size_m1_i),
    .base_o    (sp_base),
    .idx_o     (sp_idx),
    .odd_o     (sp_odd),
    .count_o   (sp_cnt)
  );

  tagchk_nib_cmp #(.CW(CW)) u_cmp (
    .byte_i (mem_rdata_i),
    .tag_i  (tag_q),
    .odd_i  (odd_q),
    .left_i (left_q),
    .mis_o  (c_mis),
    .pos_o  (c_pos),
    .used_o (c_used),
    .fin_o  (c_fin)
  );

  assign accept = (st_q == ST_IDLE) && req_i;
  assign f_n    = n_q + CW'(c_pos);
  // first granule reports the unaligned start
  assign f_addr = (f_n == '0) ? start_q : base_q + (AW'(f_n) << GL);

  always_comb begin
    mem_req_o  = 1'b0;
    mem_addr_o = idx_q;
    unique case (st_q)
      ST_FETCH: mem_req_o = 1'b1;
      ST_CMP: begin
        mem_req_o  = !c_fin;
        mem_addr_o = idx_q + IW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      start_q <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      odd_q   <= 1'b0;
      left_q  <= '0;
      n_q     <= '0;
      tag_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fault_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (!chk_en_i) begin
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
              fault_q <= '0;
            end else begin
              st_q    <= ST_FETCH;
              start_q <= addr_i;
              base_q  <= sp_base;
              idx_q   <= sp_idx;
              odd_q   <= sp_odd;
              left_q  <= sp_cnt;
              n_q     <= '0;
              tag_q   <= ptr_tag_i;
            end
          end
        end
        ST_FETCH: st_q <= ST_CMP;
        ST_CMP: begin
          if (c_fin) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            pass_q  <= !c_mis;
            fault_q <= c_mis ? f_addr : '0;
          end else begin
            n_q    <= n_q + CW'(c_used);
            left_q <= left_q - CW'(c_used);
            odd_q  <= 1'b0;
            idx_q  <= idx_q + IW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign fault_addr_o = fault_q;
endmodule

// File: rtl/nib_tag_checker_chk.sv
module nib_tag_checker_chk #(
  parameter int AW = 32,
  parameter int SW = 8,
  parameter int GL = 4,
  localparam int IW = AW - GL - 1,
  localparam int CW = SW - GL + 2,
  localparam int MAXB = (1 << (SW - GL - 1)) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          chk_en_i,
  input logic [AW-1:0] addr_i,
  input logic [SW-1:0] size_m1_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic [IW-1:0] mem_addr_o,
  input logic          done_o,
  input logic          pass_o,
  input logic [AW-1:0] fault_addr_o
);
  logic [AW:0]   c_start, c_end;
  logic [CW-1:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_start <= '0;
      c_end   <= '0;
      rd_cnt  <= '0;
    end else if (req_i && !busy_o) begin
      c_start <= {1'b0, addr_i};
      c_end   <= {1'b0, addr_i} + (AW+1)'(size_m1_i);
      rd_cnt  <= '0;
    end else if (mem_req_o) begin
      rd_cnt  <= rd_cnt + CW'(1);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                               // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pass_o) && $stable(fault_addr_o)));           // R8
  AST_PASS_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (fault_addr_o == '0));                      // R8
  AST_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !chk_en_i) |=> (done_o && pass_o));           // R7
  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);                                           // R7
  AST_READ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + IW'(1))); // R9
  AST_READ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (rd_cnt < CW'(MAXB)));                               // R9
  AST_FAULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> ({1'b0, fault_addr_o} >= c_start && {1'b0, fault_addr_o} <= c_end)); // R6
endmodule

bind nib_tag_checker nib_tag_checker_chk #(.AW(AW), .SW(SW), .GL(GL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .chk_en_i     (chk_en_i),
  .addr_i       (addr_i),
  .size_m1_i    (size_m1_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .fault_addr_o (fault_addr_o)
);

// File: tb/nib_tag_checker_bench.sv
module nib_tag_checker_bench;
  localparam int AW = 32;
  localparam int SW = 8;
  localparam int GL = 4;
  localparam int IW = AW - GL - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          chk_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [SW-1:0] size_m1_i = '0;
  logic [3:0]    ptr_tag_i = '0;
  logic          busy_o, mem_req_o, done_o, pass_o;
  logic [IW-1:0] mem_addr_o;
  logic [7:0]    mem_rdata_i = '0;
  logic [AW-1:0] fault_addr_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] tmem [256];

  nib_tag_checker #(.AW(AW), .SW(SW), .GL(GL)) u_nib_tag_checker (
    .clk_i, .rst_ni, .req_i, .chk_en_i, .addr_i, .size_m1_i, .ptr_tag_i,
    .busy_o, .mem_req_o, .mem_addr_o, .mem_rdata_i, .done_o, .pass_o, .fault_addr_o
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) if (mem_req_o) mem_rdata_i <= tmem[mem_addr_o[7:0]];

  function automatic logic [3:0] tag_at(int g);
    logic [7:0] b;
    b = tmem[(g >> 1) & 255];
    return g[0] ? b[7:4] : b[3:0];
  endfunction

  task automatic set_tag(int g, logic [3:0] t);
    if (g[0]) tmem[(g >> 1) & 255][7:4] = t;
    else      tmem[(g >> 1) & 255][3:0] = t;
  endtask

  task automatic chk(string rq, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run(string rq, logic [31:0] a, logic [7:0] sz, logic [3:0] t, bit en, bit poke);
    int gf, gl, fail, g_stop, exp_bytes, exp_lat, lat, reads;
    longint exp_fault, first_rd, got_fault;
    bit exp_pass, got_pass;
    gf = int'(a >> 4);
    gl = int'((a + 32'(sz)) >> 4);
    fail = -1;
    if (en)
      for (int i = 0; i <= gl - gf; i++)
        if (tag_at(gf + i) != t) begin fail = i; break; end
    exp_pass  = (fail < 0);
    exp_fault = (fail < 0) ? 0 : (fail == 0 ? longint'(a) : longint'(gf + fail) * 16);
    g_stop    = (fail < 0) ? gl : gf + fail;
    exp_bytes = en ? (g_stop >> 1) - (gf >> 1) + 1 : 0;
    exp_lat   = en ? exp_bytes + 1 : 0;

    @(negedge clk_i);
    req_i = 1'b1; addr_i = a; size_m1_i = sz; ptr_tag_i = t; chk_en_i = en;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    lat = -1; reads = 0; first_rd = -1; got_pass = 1'b0; got_fault = -1;
    for (int k = 0; k < 60; k++) begin
      if (mem_req_o) begin
        if (first_rd < 0) first_rd = longint'(mem_addr_o);
        reads++;
      end
      if (done_o) begin
        lat = k; got_pass = pass_o; got_fault = longint'(fault_addr_o);
        break;
      end
      if (poke && k == 1) begin
        req_i = 1'b1; addr_i = a ^ 32'h40; ptr_tag_i = ~t; chk_en_i = 1'b1;
      end else begin
        req_i = 1'b0;
      end
      @(negedge clk_i);
    end
    req_i = 1'b0;
    chk(rq, "pass", longint'(got_pass), longint'(exp_pass));
    chk(rq, "fault_addr", got_fault, exp_fault);
    chk("R9", "latency", lat, exp_lat);
    chk("R9", "reads", reads, exp_bytes);
    if (exp_bytes > 0) chk("R1", "first tag byte", first_rd, longint'(a >> 5));
    @(negedge clk_i);
    chk("R8", "done pulse width", longint'(done_o), 0);
    chk("R8", "pass held", longint'(pass_o), longint'(exp_pass));
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'h55;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8", "reset done", longint'(done_o), 0);
    chk("R8", "reset busy", longint'(busy_o), 0);
    chk("R8", "reset fault", longint'(fault_addr_o), 0);

    run("R4", 32'h100, 8'd15, 4'h5, 1'b1, 1'b0);   // single granule match
    run("R2", 32'h200, 8'd255, 4'h5, 1'b1, 1'b0);  // 16 granules, 8 bytes
    set_tag(32'h30, 4'hA);                        // skipped low nibble
    run("R3", 32'h318, 8'd255, 4'h5, 1'b1, 1'b0);  // 17 granules, 9 bytes
    set_tag(32'h44, 4'h3);
    run("R5", 32'h447, 8'd31, 4'h5, 1'b1, 1'b0);   // first granule fails
    set_tag(32'h52, 4'h9);
    run("R6", 32'h508, 8'd63, 4'h5, 1'b1, 1'b0);   // low nibble fail, n=2
    set_tag(32'h63, 4'h1);
    run("R6", 32'h600, 8'd127, 4'h5, 1'b1, 1'b0);  // high nibble fail, n=3
    run("R7", 32'h440, 8'd31, 4'h5, 1'b0, 1'b0);   // unchecked over bad tag
    run("R10", 32'h700, 8'd255, 4'h5, 1'b1, 1'b1); // request while busy
    set_tag(32'h86, 4'hC);
    run("R2", 32'h85C, 8'd7, 4'h5, 1'b1, 1'b0);    // short access spans 2 granules
    set_tag(32'h91, 4'h2);
    run("R1", 32'h900, 8'd31, 4'h5, 1'b1, 1'b0);   // higher granule in [7:4]

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule